// File: doc/BRIEF.md
# Periodic Interrupt Generator

This block produces an active-low interrupt request for a real-time clock from the clock's own timekeeping events. A 3-bit select field picks one behaviour from eight:
- the output released,
- the output held low,
- a 2 Hz or a 1 Hz square wave with 50% duty, derived from the sub-second prescaler phase,
- a level interrupt on a chosen event: each second, each minute, each hour or each month.

In level mode the chosen event sets a sticky flag, and the output stays low until the host clears that flag.

The surrounding clock supplies several inputs:
- the current value of its sub-second prescaler,
- single-cycle strobes for the seconds, minutes and hours increments and for the month rollover,
- the select code, held in a host register,
- a one-cycle pulse when the host writes zero to the flag.

The square waves are placed so that their falling edge comes a fixed number of prescaler counts before the seconds increment. A host that writes the seconds counter clears the prescaler, so in pulse mode the output is driven low at that point. The output models an open-drain pin: 1 means released. It is released after reset.

Top module: `periodic_irq`

## Requirements
- R1: During and directly after reset, `intN` is 1 (released) and `flagOut` is 0.
- R2: With `intSel` = 3'b000, `intN` is 1 on the edge after the code is applied, whatever the strobes and phase are.
- R3: With `intSel` = 3'b001, `intN` is 0 on the edge after the code is applied.
- R4: With `intSel` = 3'b010 (2 Hz), let s = (`subPhase` + LAG) mod 2^PHASE_W. `intN` is 0 when bit PHASE_W-2 of s is 0 and 1 otherwise. The output is registered one edge after the phase is presented.
- R5: With `intSel` = 3'b011 (1 Hz), using s from R4, `intN` is 0 when bit PHASE_W-1 of s is 0 and 1 otherwise. The output is registered one edge later.
- R6: A `subPhase` of 0 (the prescaler just cleared by a seconds write) drives `intN` low in both pulse modes.
- R7: In both pulse modes the falling edge of `intN` occurs at `subPhase` = 2^PHASE_W - LAG, which is LAG prescaler counts before the wrap that increments seconds. At the count just before that, `intN` is still high.
- R8: The level-mode codes map to events as follows: 3'b100 to `evtSec`, 3'b101 to `evtMin`, 3'b110 to `evtHour` and 3'b111 to `evtMonth`. A strobe that does not match the current code has no effect on the flag or the output.
- R9: A matching event sets `flagOut` to 1 and drives `intN` to 0 on the next edge.
- R10: The flag is sticky. Further events while it is set leave it at 1. Only `flagClr` clears it, and an event in the same cycle as `flagClr` wins, so the flag stays 1.
- R11: In level mode, `flagClr` with no matching event clears `flagOut` and releases `intN` to 1 on the next edge.
- R12: Strobes arriving while `intSel[2]` is 0 never set the flag. An existing flag keeps its value when the code leaves level mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset (cold power-on) |
| subPhase | input | PHASE_W | Sub-second prescaler value; it wraps to 0 when seconds increment |
| evtSec | input | 1 | One-cycle strobe on a seconds increment |
| evtMin | input | 1 | One-cycle strobe on a minutes increment (second 00) |
| evtHour | input | 1 | One-cycle strobe on an hours increment (minute 00, second 00) |
| evtMonth | input | 1 | One-cycle strobe on a month rollover (day 1, 00:00:00) |
| intSel | input | 3 | Interrupt mode select code |
| flagClr | input | 1 | One-cycle pulse when the host writes 0 to the flag |
| intN | output | 1 | Active-low interrupt; 1 means released |
| flagOut | output | 1 | Sticky level-mode flag, readable by the host |

## Verification
Every result of this block is registered once: a select code, a prescaler phase, a strobe or a clear presented before a rising edge appears on `intN` and `flagOut` right after that edge, and no result takes longer. The bench drives each cycle's inputs at a falling edge and advances its behavioural reference model at the rising edge. At the next falling edge, half a cycle later, it compares both outputs with the model. A one-cycle shift in either direction, such as a pulse waveform offset by one prescaler count or a flag that lags its event, shows up as a mismatch at that comparison.

// File: rtl/periodic_irq_pkg.sv
package periodic_irq_pkg;

  typedef enum logic [2:0] {
    SEL_OFF   = 3'b000,
    SEL_LOW   = 3'b001,
    SEL_P2HZ  = 3'b010,
    SEL_P1HZ  = 3'b011,
    SEL_LSEC  = 3'b100,
    SEL_LMIN  = 3'b101,
    SEL_LHOUR = 3'b110,
    SEL_LMON  = 3'b111
  } selCode_e;

  localparam int NUM_EVENTS = 4;

  typedef struct packed {
    logic levelMode;
    logic forceLow;
    logic pulseOn;
    logic fastRate;
    logic eventHit;
  } ctrlStrobe_t;

endpackage

// File: rtl/periodic_irq_ctrl.sv
module periodic_irq_ctrl
  import periodic_irq_pkg::*;
(
  input  logic [2:0]            intSel,
  input  logic [NUM_EVENTS-1:0] evtVec,
  output ctrlStrobe_t           strobe
);

  selCode_e selCode;
  logic [NUM_EVENTS-1:0] evtMatch;

  always_comb selCode = selCode_e'(intSel);

  // One matcher per level-mode code; low two bits choose the event.
  for (genvar g = 0; g < NUM_EVENTS; g++) begin : g_match
    assign evtMatch[g] = intSel[2] && (intSel[1:0] == 2'(g)) && evtVec[g];
  end

  always_comb begin
    strobe           = '0;
    strobe.eventHit  = |evtMatch;
    unique case (selCode)
      SEL_OFF:  ;
      SEL_LOW:  strobe.forceLow = 1'b1;
      SEL_P2HZ: begin
        strobe.pulseOn  = 1'b1;
        strobe.fastRate = 1'b1;
      end
      SEL_P1HZ: strobe.pulseOn = 1'b1;
      default:  strobe.levelMode = 1'b1;
    endcase
  end

endmodule

// File: rtl/periodic_irq_datapath.sv
module periodic_irq_datapath
  import periodic_irq_pkg::*;
#(
  parameter int PHASE_W = 15,
  parameter int LAG     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PHASE_W-1:0] subPhase,
  input  logic               flagClr,
  input  ctrlStrobe_t        strobe,
  output logic               intN,
  output logic               flag
);

  localparam logic [PHASE_W-1:0] LAG_V = PHASE_W'(LAG);

  logic [PHASE_W-1:0] shifted;
  logic pulseLow;
  logic flagNext;
  logic intNNext;

  always_comb begin
    shifted  = subPhase + LAG_V;
    pulseLow = strobe.fastRate ? ~shifted[PHASE_W-2] : ~shifted[PHASE_W-1];
  end

  always_comb begin
    if (strobe.eventHit)  flagNext = 1'b1;
    else if (flagClr)     flagNext = 1'b0;
    else                  flagNext = flag;
  end

  always_comb begin
    if (strobe.forceLow)       intNNext = 1'b0;
    else if (strobe.levelMode) intNNext = ~flagNext;
    else if (strobe.pulseOn)   intNNext = ~pulseLow;
    else                       intNNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag <= 1'b0;
      intN <= 1'b1;
    end else begin
      flag <= flagNext;
      intN <= intNNext;
    end
  end

  // R9: a matching event raises the flag and pulls the line low
  a_r9_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    strobe.eventHit |=> (flag && !intN));

  // R10: the flag only falls on a clear
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !flagClr) |=> flag);

  // R11: a clear without an event drops the flag
  a_r11_clear: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !strobe.eventHit) |=> !flag);

  // R3: forced-low code
  a_r3_force_low: assert property (@(posedge clk) disable iff (!rstN)
    strobe.forceLow |=> !intN);

endmodule

// File: rtl/periodic_irq.sv
module periodic_irq
  import periodic_irq_pkg::*;
#(
  parameter int PHASE_W = 15,
  parameter int LAG     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PHASE_W-1:0] subPhase,
  input  logic               evtSec,
  input  logic               evtMin,
  input  logic               evtHour,
  input  logic               evtMonth,
  input  logic [2:0]         intSel,
  input  logic               flagClr,
  output logic               intN,
  output logic               flagOut
);

  ctrlStrobe_t strobe;
  logic [NUM_EVENTS-1:0] evtVec;

  assign evtVec = {evtMonth, evtHour, evtMin, evtSec};

  periodic_irq_ctrl u_ctrl (
    .intSel (intSel),
    .evtVec (evtVec),
    .strobe (strobe)
  );

  periodic_irq_datapath #(
    .PHASE_W (PHASE_W),
    .LAG     (LAG)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .subPhase (subPhase),
    .flagClr  (flagClr),
    .strobe   (strobe),
    .intN     (intN),
    .flag     (flagOut)
  );

  // R2: off code releases the line
  a_r2_off_high: assert property (@(posedge clk) disable iff (!rstN)
    (intSel == 3'b000) |=> intN);

  // R12: outside level mode a clear flag stays clear
  a_r12_no_set: assert property (@(posedge clk) disable iff (!rstN)
    (!intSel[2] && !flagOut) |=> !flagOut);

endmodule

// File: tb/periodic_irq_test.sv
module periodic_irq_test;

  localparam int PHASE_W = 15;
  localparam int LAG     = 3;
  localparam int FULL    = 1 << PHASE_W;
  localparam int HALF    = FULL / 2;
  localparam int QUART   = FULL / 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PHASE_W-1:0] subPhase = '0;
  logic evtSec = 0, evtMin = 0, evtHour = 0, evtMonth = 0;
  logic [2:0] intSel = 3'b000;
  logic flagClr = 0;
  logic intN, flagOut;

  int checks = 0;
  int fails  = 0;
  bit mFlag  = 0;
  bit mInt   = 1;

  always #4 clk = ~clk;

  periodic_irq #(.PHASE_W(PHASE_W), .LAG(LAG)) uut (
    .clk(clk), .rstN(rstN), .subPhase(subPhase),
    .evtSec(evtSec), .evtMin(evtMin), .evtHour(evtHour), .evtMonth(evtMonth),
    .intSel(intSel), .flagClr(flagClr), .intN(intN), .flagOut(flagOut)
  );

  task automatic compare(input string tag);
    checks++;
    if (intN !== mInt || flagOut !== mFlag) begin
      fails++;
      $display("FAIL %s: intN=%0b flag=%0b expected intN=%0b flag=%0b (sel=%0d phase=%0d)",
               tag, intN, flagOut, mInt, mFlag, intSel, subPhase);
    end
  endtask

  // Applies one cycle of inputs, advances the model at the edge, compares after.
  task automatic step(input logic [2:0] s, input int ph,
                      input bit es, input bit em, input bit eh, input bit emo,
                      input bit clr, input string tag);
    bit evt;
    int sh;
    intSel = s; subPhase = PHASE_W'(ph);
    evtSec = es; evtMin = em; evtHour = eh; evtMonth = emo; flagClr = clr;
    @(posedge clk);
    evt = (s == 3'd4 && es) || (s == 3'd5 && em) || (s == 3'd6 && eh) || (s == 3'd7 && emo);
    if (evt) mFlag = 1;
    else if (clr) mFlag = 0;
    sh = (ph + LAG) % FULL;
    case (s)
      3'd0: mInt = 1;
      3'd1: mInt = 0;
      3'd2: mInt = !((sh % HALF) < QUART);
      3'd3: mInt = !(sh < HALF);
      default: mInt = !mFlag;
    endcase
    @(negedge clk);
    compare(tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    // R2: off mode ignores strobes and phase
    step(3'd0, 0, 1, 1, 1, 1, 0, "R2");
    step(3'd0, 12345, 0, 0, 0, 0, 0, "R2");
    // R3: forced low
    step(3'd1, 0, 0, 0, 0, 0, 0, "R3");
    step(3'd1, 20000, 1, 0, 0, 0, 0, "R3");
    // R6: cleared prescaler pulls pulse output low
    step(3'd2, 0, 0, 0, 0, 0, 0, "R6 2Hz");
    step(3'd3, 0, 0, 0, 0, 0, 0, "R6 1Hz");
    // R7: falling edge position
    step(3'd3, FULL - LAG - 1, 0, 0, 0, 0, 0, "R7 before fall 1Hz");
    step(3'd3, FULL - LAG, 0, 0, 0, 0, 0, "R7 fall 1Hz");
    step(3'd2, FULL - LAG - 1, 0, 0, 0, 0, 0, "R7 before fall 2Hz");
    step(3'd2, FULL - LAG, 0, 0, 0, 0, 0, "R7 fall 2Hz");
    // R4 / R5 boundaries and sweeps
    step(3'd2, QUART - LAG - 1, 0, 0, 0, 0, 0, "R4 edge");
    step(3'd2, QUART - LAG, 0, 0, 0, 0, 0, "R4 edge");
    step(3'd2, HALF - LAG, 0, 0, 0, 0, 0, "R4 edge");
    step(3'd3, HALF - LAG - 1, 0, 0, 0, 0, 0, "R5 edge");
    step(3'd3, HALF - LAG, 0, 0, 0, 0, 0, "R5 edge");
    for (int p = 0; p < FULL; p += 97) step(3'd2, p, 0, 0, 0, 0, 0, "R4 sweep");
    for (int p = 5; p < FULL; p += 101) step(3'd3, p, 0, 0, 0, 0, 0, "R5 sweep");

    // R12: strobes in pulse/off modes never set the flag
    step(3'd2, 100, 1, 1, 1, 1, 0, "R12");
    step(3'd3, 100, 1, 1, 1, 1, 0, "R12");

    // R8/R9: second level mode
    step(3'd4, 0, 0, 0, 0, 0, 0, "R8 idle");
    step(3'd4, 0, 0, 1, 1, 1, 0, "R8 mismatched");
    step(3'd4, 0, 1, 0, 0, 0, 0, "R9 sec event");
    step(3'd4, 0, 0, 0, 0, 0, 0, "R10 holds");
    step(3'd4, 0, 1, 0, 0, 0, 0, "R10 repeat");
    step(3'd4, 0, 0, 0, 0, 0, 1, "R11 clear");
    step(3'd4, 0, 0, 0, 0, 0, 0, "R11 stays released");
    step(3'd4, 0, 1, 0, 0, 0, 1, "R10 event beats clear");
    step(3'd4, 0, 0, 0, 0, 0, 1, "R11 clear");

    // R8: each remaining level code
    step(3'd5, 0, 1, 0, 1, 1, 0, "R8 min mismatched");
    step(3'd5, 0, 0, 1, 0, 0, 0, "R8 min event");
    step(3'd5, 0, 0, 0, 0, 0, 1, "R11 clear");
    step(3'd6, 0, 1, 1, 0, 1, 0, "R8 hour mismatched");
    step(3'd6, 0, 0, 0, 1, 0, 0, "R8 hour event");
    step(3'd6, 0, 0, 0, 0, 0, 1, "R11 clear");
    step(3'd7, 0, 1, 1, 1, 0, 0, "R8 month mismatched");
    step(3'd7, 0, 0, 0, 0, 1, 0, "R8 month event");

    // R12: flag kept when leaving level mode; released output in off mode
    step(3'd0, 0, 0, 0, 0, 0, 0, "R12 flag kept");
    step(3'd4, 0, 0, 0, 0, 0, 0, "R9 low again");
    step(3'd1, 0, 0, 0, 0, 0, 1, "R11 clear outside level");
    step(3'd7, 0, 0, 0, 0, 0, 0, "R11 released");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule